// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned operands and an incoming carry, and returns the sum together with the carry-out. It is purely combinational: the result settles in the same cycle as the operands and is meant to sit inside a wider datapath stage, with the surrounding logic owning any registers.

The operand width is a parameter that takes 16, 32 or 64. The adder is a chain of segments. The lowest segment is a 2-bit ripple adder. Above it sit carry-select segments, and the widths of these grow along a fixed, irregular sequence for each supported width. Each select segment first forms a per-bit propagate word (operands XORed) and a generate word (operands ANDed). From these it builds two full carry words: one that assumes an incoming carry of 0 and one that assumes 1. Once the real incoming carry is known, the segment keeps one carry word. It then forms its sum bits from that word and the propagate word. The selection uses the fact that the carry word built under a 0 input never has a 1 where the other word has a 0. Because of that ordering, each selected bit costs one AND-OR instead of a multiplexer.

Top module: `csa_sqrt_adder`

## Requirements
- R1: With WIDTH=16, {cout, sum} equals opa + opb + cin for every input combination, where cin is weighted 1.
- R2: With WIDTH=32, {cout, sum} equals opa + opb + cin for every input combination.
- R3: With WIDTH=64, {cout, sum} equals opa + opb + cin for every input combination.
- R4: Inside every select segment, wherever the carry word that assumes carry-in 0 has a 1, the carry word that assumes carry-in 1 also has a 1.
- R5: Every select segment's carry-out equals the carry out of the true sum of its operand slices plus its incoming carry. That carry-out drives the next segment's carry-in, so a carry that starts at bit 0 reaches cout through all segments (all-ones plus zero with cin=1 gives sum 0 and cout 1).
- R6: With cin=0, all-ones plus zero gives all-ones with cout 0. All-zero operands with cin=0 give sum 0 and cout 0.
- R7: The 2-bit ripple segment at the bottom returns its 2-bit slice sum and carry exactly. A carry generated at the top bit of any segment is added into the bottom bit of the segment above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand, unsigned |
| opb | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Incoming carry, weight 1 |
| sum | output | WIDTH | Low WIDTH bits of opa + opb + cin |
| cout | output | 1 | Carry out of the top segment |

## Verification
Every output is due in the same cycle as its inputs, with no register on the path. The bench therefore drives operands just after a rising edge and samples sum and cout at the following falling edge. That leaves half a period for the carry chain to settle, and each sample is compared against a reference sum computed in a wider integer. All three supported widths are instantiated side by side and fed the same low-order operand bits, so one stimulus step checks each width in the same sample window.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int MAX_SEGS = 10;

  function automatic bit width_ok(input int w);
    return (w == 16) || (w == 32) || (w == 64);
  endfunction

  function automatic int seg_count(input int w);
    case (w)
      16:      return 5;
      32:      return 7;
      default: return 10;
    endcase
  endfunction

  // segment 0 is the 2-bit ripple part; higher indices are select segments
  function automatic int seg_width(input int w, input int k);
    int r;
    r = 0;
    case (k)
      0: r = 2;
      1: r = 2;
      2: r = 3;
      3: r = 4;
      4: r = (w == 16) ? 5 : 6;
      5: r = 7;
      6: r = 8;
      7: r = 9;
      8: r = 11;
      9: r = 12;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic int seg_base(input int w, input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < MAX_SEGS; j++) begin
      if (j < k) acc += seg_width(w, j);
    end
    return acc;
  endfunction

endpackage

// File: rtl/csa_rca_seg.sv
module csa_rca_seg #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] rc;

  assign rc[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]    = a[i] ^ b[i] ^ rc[i];
    assign rc[i+1] = (a[i] & b[i]) | (rc[i] & (a[i] ^ b[i]));
  end

  assign co = rc[W];

  always_comb begin
    if (!$isunknown({a, b, ci})) begin
      AST_RCA_SUM: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci})); // R7
    end
  end
endmodule

// File: rtl/csa_carry_gen.sv
module csa_carry_gen #(
  parameter int W        = 4,
  parameter bit CARRY_IN = 1'b0
) (
  input  logic [W-1:0] hs,
  input  logic [W-1:0] hc,
  output logic [W-1:0] cw
);
  if (CARRY_IN) begin : g_lsb_one
    assign cw[0] = hc[0] | hs[0];
  end else begin : g_lsb_zero
    assign cw[0] = hc[0];
  end

  for (genvar i = 1; i < W; i++) begin : g_chain
    assign cw[i] = hc[i] | (hs[i] & cw[i-1]);
  end
endmodule

// File: rtl/csa_sel_seg.sv
module csa_sel_seg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] hs, hc, cw_lo, cw_hi, cw_sel;

  assign hs = a ^ b;
  assign hc = a & b;

  csa_carry_gen #(.W(W), .CARRY_IN(1'b0)) u_cg_lo (
    .hs(hs), .hc(hc), .cw(cw_lo)
  );

  csa_carry_gen #(.W(W), .CARRY_IN(1'b1)) u_cg_hi (
    .hs(hs), .hc(hc), .cw(cw_hi)
  );

  // ordering cw_lo <= cw_hi lets an AND-OR stand in for a mux
  assign cw_sel = cw_lo | ({W{ci}} & cw_hi);

  assign co   = cw_sel[W-1];
  assign s[0] = hs[0] ^ ci;
  assign s[W-1:1] = hs[W-1:1] ^ cw_sel[W-2:0];

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_CARRY_ORDER: assert ((cw_lo & ~cw_hi) == '0); // R4
    end
    if (!$isunknown({a, b, ci})) begin
      AST_SEG_COUT: assert (co == (({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}) >> W)); // R5
    end
  end
endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import csa_pkg::*;

  localparam int NSEG = seg_count(WIDTH);

  if (!width_ok(WIDTH)) begin : g_bad_width
    $error("csa_sqrt_adder: WIDTH must be 16, 32 or 64");
  end

  logic [NSEG:0] seg_c;
  assign seg_c[0] = cin;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int SW = seg_width(WIDTH, k);
    localparam int SB = seg_base(WIDTH, k);
    if (k == 0) begin : g_rca
      csa_rca_seg #(.W(SW)) u_rca (
        .a (opa[SB +: SW]),
        .b (opb[SB +: SW]),
        .ci(seg_c[k]),
        .s (sum[SB +: SW]),
        .co(seg_c[k+1])
      );
    end else begin : g_sel
      csa_sel_seg #(.W(SW)) u_sel (
        .a (opa[SB +: SW]),
        .b (opb[SB +: SW]),
        .ci(seg_c[k]),
        .s (sum[SB +: SW]),
        .co(seg_c[k+1])
      );
    end
  end

  assign cout = seg_c[NSEG];

  always_comb begin
    if (!$isunknown({opa, opb, cin})) begin
      AST_SUM_MATCH: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin})); // R1
    end
  end
endmodule

// File: tb/csa_sqrt_adder_bench.sv
module csa_sqrt_adder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] a64, b64;
  logic        ci;
  logic [15:0] s16; logic c16;
  logic [31:0] s32; logic c32;
  logic [63:0] s64; logic c64;

  csa_sqrt_adder #(.WIDTH(16)) u_csa_sqrt_adder (
    .opa(a64[15:0]), .opb(b64[15:0]), .cin(ci), .sum(s16), .cout(c16));
  csa_sqrt_adder #(.WIDTH(32)) u_csa_sqrt_adder_w32 (
    .opa(a64[31:0]), .opb(b64[31:0]), .cin(ci), .sum(s32), .cout(c32));
  csa_sqrt_adder #(.WIDTH(64)) u_csa_sqrt_adder_w64 (
    .opa(a64), .opb(b64), .cin(ci), .sum(s64), .cout(c64));

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        c;
    logic [16:0] r;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 16'h0000, 1'b0, 17'h00000},
    '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},
    '{16'hFFFF, 16'h0000, 1'b1, 17'h10000},
    '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    '{16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
    '{16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    '{16'h1234, 16'h4321, 1'b0, 17'h05555},
    '{16'h8000, 16'h8000, 1'b0, 17'h10000},
    '{16'h0003, 16'h0001, 1'b0, 17'h00004},
    '{16'h000F, 16'h0001, 1'b0, 17'h00010},
    '{16'h01FF, 16'h0001, 1'b0, 17'h00200},
    '{16'h7FFF, 16'h0001, 1'b1, 17'h08001}
  };

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic c);
    @(posedge clk);
    #1;
    a64 = a; b64 = b; ci = c;
    @(negedge clk);
  endtask

  task automatic chk16(input logic [16:0] exp, input string tag);
    checks++;
    if ({c16, s16} !== exp) begin
      errors++;
      $display("FAIL %s w16 a=%h b=%h c=%b got=%h exp=%h", tag, a64[15:0], b64[15:0], ci, {c16, s16}, exp);
    end
  endtask

  task automatic chk32(input logic [32:0] exp, input string tag);
    checks++;
    if ({c32, s32} !== exp) begin
      errors++;
      $display("FAIL %s w32 a=%h b=%h c=%b got=%h exp=%h", tag, a64[31:0], b64[31:0], ci, {c32, s32}, exp);
    end
  endtask

  task automatic chk64(input logic [64:0] exp, input string tag);
    checks++;
    if ({c64, s64} !== exp) begin
      errors++;
      $display("FAIL %s w64 a=%h b=%h c=%b got=%h exp=%h", tag, a64, b64, ci, {c64, s64}, exp);
    end
  endtask

  // reference sums from wide integer addition
  task automatic chk_all(input string tag);
    chk16({1'b0, a64[15:0]} + {1'b0, b64[15:0]} + {16'd0, ci}, {tag, "/R1"});
    chk32({1'b0, a64[31:0]} + {1'b0, b64[31:0]} + {32'd0, ci}, {tag, "/R2"});
    chk64({1'b0, a64} + {1'b0, b64} + {64'd0, ci}, {tag, "/R3"});
  endtask

  initial begin
    a64 = '0; b64 = '0; ci = 1'b0;

    // R6: all-zero inputs give zero
    apply('0, '0, 1'b0);
    chk16(17'h0, "R6 zero");
    chk32(33'h0, "R6 zero");
    chk64(65'h0, "R6 zero");

    // R1: fixed vector table for the 16-bit adder
    for (int i = 0; i < NVEC; i++) begin
      apply({48'd0, VECS[i].a}, {48'd0, VECS[i].b}, VECS[i].c);
      chk16(VECS[i].r, "R1 table");
    end

    // R5: carry from bit 0 ripples through every segment
    apply('1, '0, 1'b1);
    chk16(17'h10000, "R5 ripple");
    chk32({1'b1, 32'h0}, "R5 ripple");
    chk64({1'b1, 64'h0}, "R5 ripple");

    // R6: all ones plus zero without carry
    apply('1, '0, 1'b0);
    chk16({1'b0, 16'hFFFF}, "R6 ones");
    chk32({1'b0, 32'hFFFF_FFFF}, "R6 ones");
    chk64({1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, "R6 ones");

    // alternating patterns
    apply({32{2'b10}}, {32{2'b01}}, 1'b0); chk_all("alt0");
    apply({32{2'b10}}, {32{2'b01}}, 1'b1); chk_all("alt1");
    apply({32{2'b10}}, {32{2'b10}}, 1'b1); chk_all("alt2");

    // R7: a generate at each bit with a propagate run above it
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 2; c++) begin
        apply((64'd1 << k) | ~((64'd1 << k) | ((64'd1 << k) - 64'd1)) & 64'h5555_5555_5555_5555,
              (64'd1 << k) | ~((64'd1 << k) | ((64'd1 << k) - 64'd1)) & 64'hAAAA_AAAA_AAAA_AAAA,
              c[0]);
        chk_all("R7 boundary");
      end
    end

    // R1: exhaustive over the low 7 bits of each operand, both carries
    for (int x = 0; x < 128; x++) begin
      for (int y = 0; y < 128; y++) begin
        for (int c = 0; c < 2; c++) begin
          apply({57'd0, x[6:0]}, {57'd0, y[6:0]}, c[0]);
          chk16({10'd0, {1'b0, x[6:0]} + {1'b0, y[6:0]} + {7'd0, c[0]}}, "R1 exhaustive");
        end
      end
    end

    // R1 R2 R3: random operands
    for (int n = 0; n < 4000; n++) begin
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()}, 1'($urandom()));
      chk_all("random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 got=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule